// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller keep running while the processor sleeps. Five gate enables leave it: the processor clock, the general I/O peripheral clock, the converter clock, the main oscillator enable and the asynchronous timer clock. While the core is awake all five are high. When the core asks to sleep and the sleep-enable bit is set, the controller captures the 3-bit mode code and drops the enables that the chosen mode stops.

Each mode also sets which wake inputs may end the sleep. Four wake sources arrive on their own pins: external interrupt, I/O peripheral interrupt, converter-done interrupt and asynchronous timer interrupt. Wake inputs and the oscillator-ready input are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. Two modes stop the main oscillator. After a wake from one of those, the controller turns the oscillator back on and holds every other domain gated until the oscillator reports ready. A synchronous reset always brings the block back to the awake state.

Top module: `slpctl_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is awake after that edge: `awake` is 1 and all five enables are 1.
- R2: Sleep starts only when `sleep_req` and `sleep_en` are both 1 at a clock edge. The outputs change after that edge. If either one is 0, the block stays awake.
- R3: Enables during sleep, listed by the mode code in `sleep_mode`. 000 (light sleep): only the processor clock stops. 001 (converter-quiet): the converter, oscillator and asynchronous timer run. 010 (deep off): all five are off. 011 (timer-only): only the asynchronous timer runs. 110 (warm standby): only the oscillator runs. 111 (warm standby with timer): the oscillator and the asynchronous timer run. `awake` is 0 in every sleep mode.
- R4: The unused codes 100 and 101 behave as code 000, both for enables and for wake rules.
- R5: In code 000, any of the four wake inputs ends the sleep.
- R6: In code 001, the external, converter and timer wake inputs end the sleep. The I/O peripheral wake input is ignored.
- R7: In codes 010 and 110, only the external wake input ends the sleep.
- R8: In codes 011 and 111, the external and timer wake inputs end the sleep. The other two are ignored.
- R9: In modes that keep the oscillator on, `awake` rises exactly `SYNC_STAGES`+1 clock edges after a qualifying wake input first appears, and not earlier.
- R10: After a qualifying wake from code 010 or 011, `osc_en` rises and the processor, I/O and converter clocks stay off until `osc_ready` has been high for `SYNC_STAGES`+1 edges. The asynchronous timer keeps the state it had in that mode. Then the block is fully awake.
- R11: While the block is awake, wake inputs have no effect and all enables stay high.
- R12: The mode code is captured when sleep starts. Changing `sleep_mode` during sleep does not change the enables or the wake rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Sleep request from the processor |
| sleep_en | input | 1 | Sleep-enable bit |
| sleep_mode | input | 3 | Mode code captured at sleep entry |
| wake_ext | input | 1 | External interrupt wake source |
| wake_io | input | 1 | I/O peripheral interrupt wake source |
| wake_adc | input | 1 | Converter-done interrupt wake source |
| wake_tmr | input | 1 | Asynchronous timer interrupt wake source |
| osc_ready | input | 1 | Main oscillator is stable |
| clk_en_cpu | output | 1 | Processor clock enable |
| clk_en_io | output | 1 | I/O peripheral clock enable |
| clk_en_adc | output | 1 | Converter clock enable |
| osc_en | output | 1 | Main oscillator enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| awake | output | 1 | Block is fully awake |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. Because the synchronizer is not bypassed, the wake latency is a real count that can be checked edge by edge, one cycle before and at the expected edge. The bench sweeps all eight mode codes against all sixteen combinations of the four wake inputs. This covers every mode's enable set, every accepted and ignored wake source, and both unused codes. The oscillator-wait path is covered for both modes that stop the oscillator.

// File: rtl/slpctl_pkg.sv
// Shared types for the sleep clock gating controller.
// Assumes the five domain enables are always packed in the order cpu, io, adc, osc, tmr.
package slpctl_pkg;

    localparam int DOM_N   = 5;
    localparam int WAKE_N  = 4;
    localparam int OSC_BIT = 1;

    typedef enum logic [2:0] {
        M_LIGHT = 3'b000,
        M_QUIET = 3'b001,
        M_DEEP  = 3'b010,
        M_TONLY = 3'b011,
        M_WARM  = 3'b110,
        M_WARMT = 3'b111
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OSCW  = 2'd2
    } slp_state_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic osc;
        logic tmr;
    } dom_t;

    typedef struct packed {
        logic ext;
        logic io;
        logic adc;
        logic tmr;
    } wake_t;

endpackage

// File: rtl/slpctl_sync.sv
// Multi-flop synchronizer for asynchronous level inputs.
// Assumes the inputs are levels held longer than STAGES cycles.
// STAGES of 0 passes the inputs straight through.
module slpctl_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] pipe [STAGES];

            // Shift the sampled inputs through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign q = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/slpctl_decode.sv
// Maps the raw 3-bit mode code to a legal mode.
// Assumes the unused codes must fall back to light sleep.
module slpctl_decode
    import slpctl_pkg::*;
(
    input  logic [2:0] code,
    output slp_mode_e  mode
);

    // Pick the legal mode, with light sleep for unused codes.
    always_comb begin
        case (code)
            3'b001:  mode = M_QUIET;
            3'b010:  mode = M_DEEP;
            3'b011:  mode = M_TONLY;
            3'b110:  mode = M_WARM;
            3'b111:  mode = M_WARMT;
            default: mode = M_LIGHT;
        endcase
    end

endmodule

// File: rtl/slpctl_policy.sv
// Policy for each mode: which domains keep running, which wake sources count,
// and whether the mode stops the main oscillator.
// Assumes a legal mode from slpctl_decode.
module slpctl_policy
    import slpctl_pkg::*;
(
    input  slp_mode_e mode,
    output dom_t      keep,
    output wake_t     allow,
    output logic      cold
);

    // Look up the policy table for the captured mode.
    always_comb begin
        keep  = '0;
        allow = '0;
        cold  = 1'b0;
        allow.ext = 1'b1;
        case (mode)
            M_QUIET: begin
                keep.adc  = 1'b1;
                keep.osc  = 1'b1;
                keep.tmr  = 1'b1;
                allow.adc = 1'b1;
                allow.tmr = 1'b1;
            end
            M_DEEP: begin
                cold = 1'b1;
            end
            M_TONLY: begin
                keep.tmr  = 1'b1;
                allow.tmr = 1'b1;
                cold      = 1'b1;
            end
            M_WARM: begin
                keep.osc = 1'b1;
            end
            M_WARMT: begin
                keep.osc  = 1'b1;
                keep.tmr  = 1'b1;
                allow.tmr = 1'b1;
            end
            default: begin
                keep.io   = 1'b1;
                keep.adc  = 1'b1;
                keep.osc  = 1'b1;
                keep.tmr  = 1'b1;
                allow.io  = 1'b1;
                allow.adc = 1'b1;
                allow.tmr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/slpctl_fsm.sv
// Sleep state machine: run, sleep, and the wait for the oscillator.
// Assumes wake and ready inputs are already synchronized.
// The mode is captured on entry.
module slpctl_fsm
    import slpctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       sleep_en,
    input  slp_mode_e  mode_sel,
    input  wake_t      wake,
    input  wake_t      allow,
    input  logic       cold,
    input  logic       osc_rdy,
    output slp_state_e state,
    output slp_mode_e  mode_q
);

    slp_state_e state_nx;
    logic       enter;
    logic       hit;

    assign enter = sleep_req && sleep_en;
    assign hit   = |(wake & allow);

    // Compute the next state.
    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:   if (enter) state_nx = ST_SLEEP;
            ST_SLEEP: if (hit)   state_nx = cold ? ST_OSCW : ST_RUN;
            ST_OSCW:  if (osc_rdy) state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    // Register the state, returning to run on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Capture the mode when sleep is entered.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mode_q <= M_LIGHT;
        else if (state == ST_RUN && enter) mode_q <= mode_sel;
    end

endmodule

// File: rtl/slpctl_gate.sv
// Builds the per-domain enables from the state and the mode's keep set.
// Assumes OSC_BIT marks the oscillator position in dom_t.
module slpctl_gate
    import slpctl_pkg::*;
(
    input  slp_state_e state,
    input  dom_t       keep,
    output dom_t       en
);

    logic             run;
    logic             oscw;
    logic [DOM_N-1:0] keep_v;
    logic [DOM_N-1:0] en_v;

    assign run    = (state == ST_RUN);
    assign oscw   = (state == ST_OSCW);
    assign keep_v = keep;

    generate
        for (genvar gi = 0; gi < DOM_N; gi++) begin : g_dom
            localparam bit IS_OSC = (gi == OSC_BIT);
            if (IS_OSC) begin : g_osc
                assign en_v[gi] = run | oscw | keep_v[gi];
            end else begin : g_plain
                assign en_v[gi] = run | keep_v[gi];
            end
        end
    endgenerate

    assign en = en_v;

endmodule

// File: rtl/slpctl_top.sv
// Top of the sleep clock gating controller. It synchronizes the asynchronous
// wake and ready inputs, runs the sleep state machine and drives the five
// domain enables. Assumes clk is an always-on clock and rst_n is synchronous.
module slpctl_top
    import slpctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       sleep_en,
    input  logic [2:0] sleep_mode,
    input  logic       wake_ext,
    input  logic       wake_io,
    input  logic       wake_adc,
    input  logic       wake_tmr,
    input  logic       osc_ready,
    output logic       clk_en_cpu,
    output logic       clk_en_io,
    output logic       clk_en_adc,
    output logic       osc_en,
    output logic       clk_en_async,
    output logic       awake
);

    localparam int SYNC_W = WAKE_N + 1;

    logic [SYNC_W-1:0] sync_d;
    logic [SYNC_W-1:0] sync_q;
    wake_t             wake_s;
    logic              rdy_s;
    slp_mode_e         mode_sel;
    slp_mode_e         mode_q;
    slp_state_e        state;
    dom_t              keep;
    wake_t             allow;
    logic              cold;
    dom_t              en;

    assign sync_d = {wake_ext, wake_io, wake_adc, wake_tmr, osc_ready};
    assign wake_s = sync_q[SYNC_W-1:1];
    assign rdy_s  = sync_q[0];

    slpctl_sync #(.STAGES(SYNC_STAGES), .W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_d),
        .q     (sync_q)
    );

    slpctl_decode u_dec (
        .code (sleep_mode),
        .mode (mode_sel)
    );

    slpctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .sleep_en  (sleep_en),
        .mode_sel  (mode_sel),
        .wake      (wake_s),
        .allow     (allow),
        .cold      (cold),
        .osc_rdy   (rdy_s),
        .state     (state),
        .mode_q    (mode_q)
    );

    slpctl_policy u_pol (
        .mode  (mode_q),
        .keep  (keep),
        .allow (allow),
        .cold  (cold)
    );

    slpctl_gate u_gate (
        .state (state),
        .keep  (keep),
        .en    (en)
    );

    assign clk_en_cpu   = en.cpu;
    assign clk_en_io    = en.io;
    assign clk_en_adc   = en.adc;
    assign osc_en       = en.osc;
    assign clk_en_async = en.tmr;
    assign awake        = (state == ST_RUN);

endmodule

// File: rtl/slpctl_chk.sv
// Port-level checker for slpctl_top, bound to every instance.
// Assumes synchronous active-low reset.
module slpctl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic sleep_en,
    input logic clk_en_cpu,
    input logic clk_en_io,
    input logic clk_en_adc,
    input logic osc_en,
    input logic clk_en_async,
    input logic awake
);

    logic all_on;
    assign all_on = clk_en_cpu && clk_en_io && clk_en_adc && osc_en && clk_en_async;

    a_r1_reset_wakes: assert property (@(posedge clk)
        !rst_n |=> (awake && all_on));

    a_r1_awake_full: assert property (@(posedge clk) disable iff (!rst_n)
        awake |-> all_on);

    a_r2_stay_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !(sleep_req && sleep_en)) |=> awake);

    a_r3_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> !clk_en_cpu);

    a_r10_no_clock_without_osc: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !(clk_en_cpu || clk_en_io || clk_en_adc));

    a_r3_io_needs_adc: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_io |-> clk_en_adc);

endmodule

bind slpctl_top slpctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .sleep_en     (sleep_en),
    .clk_en_cpu   (clk_en_cpu),
    .clk_en_io    (clk_en_io),
    .clk_en_adc   (clk_en_adc),
    .osc_en       (osc_en),
    .clk_en_async (clk_en_async),
    .awake        (awake)
);

// File: tb/sim_slpctl_top.sv
module sim_slpctl_top;

    localparam int STG = 2;
    localparam int LAT = STG + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       sleep_en = 1'b0;
    logic [2:0] sleep_mode = 3'b000;
    logic       wake_ext = 1'b0;
    logic       wake_io = 1'b0;
    logic       wake_adc = 1'b0;
    logic       wake_tmr = 1'b0;
    logic       osc_ready = 1'b1;
    logic       clk_en_cpu, clk_en_io, clk_en_adc, osc_en, clk_en_async, awake;
    logic [4:0] en_v;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slpctl_top #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
        .sleep_mode(sleep_mode), .wake_ext(wake_ext), .wake_io(wake_io),
        .wake_adc(wake_adc), .wake_tmr(wake_tmr), .osc_ready(osc_ready),
        .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io), .clk_en_adc(clk_en_adc),
        .osc_en(osc_en), .clk_en_async(clk_en_async), .awake(awake)
    );

    assign en_v = {clk_en_cpu, clk_en_io, clk_en_adc, osc_en, clk_en_async};

    // Enable order {cpu, io, adc, osc, tmr}, as given in R3.
    function automatic logic [4:0] keep_of(input logic [2:0] c);
        case (c)
            3'b001:  return 5'b00111;
            3'b010:  return 5'b00000;
            3'b011:  return 5'b00001;
            3'b110:  return 5'b00010;
            3'b111:  return 5'b00011;
            default: return 5'b01111;
        endcase
    endfunction

    // Wake order {ext, io, adc, tmr}, as given in R5 to R8.
    function automatic logic [3:0] allow_of(input logic [2:0] c);
        case (c)
            3'b001:         return 4'b1011;
            3'b010, 3'b110: return 4'b1000;
            3'b011, 3'b111: return 4'b1001;
            default:        return 4'b1111;
        endcase
    endfunction

    function automatic bit cold_of(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b011);
    endfunction

    function automatic string rule_of(input logic [2:0] c);
        case (c)
            3'b001:         return "R6";
            3'b010, 3'b110: return "R7";
            3'b011, 3'b111: return "R8";
            default:        return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Compare {awake, en_v} with the expected value.
    task automatic check_out(input logic exp_awake, input logic [4:0] exp_en, input string tag);
        check({awake, en_v} === {exp_awake, exp_en}, tag, {awake, en_v}, {exp_awake, exp_en});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_wake(input logic [3:0] p);
        {wake_ext, wake_io, wake_adc, wake_tmr} = p;
    endtask

    task automatic run_case(input logic [2:0] c, input logic [3:0] pat);
        logic [4:0] keep;
        logic [3:0] alw;
        bit         cold;
        string      mtag;
        keep = keep_of(c);
        alw  = allow_of(c);
        cold = cold_of(c);
        mtag = (c == 3'b100 || c == 3'b101) ? "R4" : "R3";
        // Enter sleep (R2).
        sleep_req = 1'b1; sleep_en = 1'b1; sleep_mode = c; osc_ready = 1'b0;
        cycles(1);
        sleep_req = 1'b0;
        sleep_mode = ~c;  // R12: the mode code changes while asleep
        check_out(1'b0, keep, mtag);
        cycles(1);
        check_out(1'b0, keep, "R12");
        set_wake(pat);
        if (|(pat & alw)) begin
            cycles(LAT - 1);
            check_out(1'b0, keep, "R9");
            cycles(1);
            if (cold) begin
                check_out(1'b0, keep | 5'b00010, "R10");
                set_wake(4'b0);
                cycles(3);
                check_out(1'b0, keep | 5'b00010, "R10");
                osc_ready = 1'b1;
                cycles(LAT - 1);
                check_out(1'b0, keep | 5'b00010, "R10");
                cycles(1);
                check_out(1'b1, 5'b11111, "R10");
            end else begin
                check_out(1'b1, 5'b11111, rule_of(c));
            end
        end else begin
            cycles(LAT + 3);
            check_out(1'b0, keep, rule_of(c));
            set_wake(4'b1000);
            osc_ready = 1'b1;
            cycles(LAT + 4);
            check_out(1'b1, 5'b11111, rule_of(c));
        end
        set_wake(4'b0);
        osc_ready = 1'b1;
        sleep_mode = 3'b000;
        cycles(LAT + 3);
    endtask

    initial begin
        cycles(3);
        check_out(1'b1, 5'b11111, "R1");
        rst_n = 1'b1;
        cycles(LAT + 2);
        check_out(1'b1, 5'b11111, "R1");

        // R2: request without the enable bit, and the enable bit without a request.
        sleep_req = 1'b1; sleep_en = 1'b0; sleep_mode = 3'b010;
        cycles(2);
        check_out(1'b1, 5'b11111, "R2");
        sleep_req = 1'b0; sleep_en = 1'b1;
        cycles(2);
        check_out(1'b1, 5'b11111, "R2");
        sleep_en = 1'b0;

        // R11: wake inputs while awake.
        set_wake(4'b1111);
        cycles(LAT + 3);
        check_out(1'b1, 5'b11111, "R11");
        set_wake(4'b0);
        cycles(LAT + 2);

        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 16; p++) begin
                run_case(3'(c), 4'(p));
            end
        end

        // R1: reset during deep sleep.
        sleep_req = 1'b1; sleep_en = 1'b1; sleep_mode = 3'b010; osc_ready = 1'b0;
        cycles(1);
        sleep_req = 1'b0;
        check_out(1'b0, 5'b00000, "R3");
        rst_n = 1'b0;
        cycles(1);
        check_out(1'b1, 5'b11111, "R1");
        rst_n = 1'b1;
        osc_ready = 1'b1;
        cycles(2);
        check_out(1'b1, 5'b11111, "R1");

        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule